// File: doc/BRIEF.md
# AC'97 Codec Register Access Engine

This block carries host accesses to the control registers of an external AC'97 codec through the command and status slots of the serial frame. The host loads a command word, and for a write also a data word, into two transmit holding registers. The engine passes them to the frame-slot interface at the next frame strobe. Status and data words that come back from the codec are captured into two receive holding registers. The host reads them out and clears them.

A write leaves the engine only when both its address word and its data word are present. Both then go out in the same frame, with both slot tags valid. A read request goes out alone, with the data slot tag left invalid. A read has completed once both receive slots hold fresh, valid words. The serial bit clock, the bit shifting and the PCM audio slots belong to other blocks.

Top module: `codec_reg_engine`

## Requirements
- R1: After reset, both transmit busy flags, both receive valid flags and the read-done flag are 0. The transmitted slot words, their tags and both receive words are all zero.
- R2: A load of the slot 2 holding register sets tx2 busy in the next cycle. A load of the slot 1 holding register sets tx1 busy in the next cycle.
- R3: A slot 1 word with bit 19 = 1 is a read request. At a frame strobe with tx1 busy and the slot 1 enable set, it appears on the slot 1 output in the next cycle, with tag1 = 1, tag2 = 0 and slot 2 = 0. Tx1 busy clears and tx2 busy keeps its value.
- R4: A slot 1 word with bit 19 = 0 is a write, with the register index in bits 18:12 and the data in bits 19:4 of the slot 2 word. At a frame strobe with both busy flags set and both enables set, both words go out in the same frame with tag1 = tag2 = 1, and both busy flags clear.
- R5: A write whose slot 2 word has not been loaded is held. Frames carry tag1 = 0 and tag2 = 0, and tx1 busy stays set until a slot 2 word is loaded and sent.
- R6: A read is not sent while the slot 1 enable is clear. A write is not sent unless both slot enables are set. A held request keeps its busy flags and produces untagged, zero slots.
- R7: At a receive strobe, each slot whose tag is set is captured into its receive word and sets its valid flag. A newer capture overwrites an unread value. A slot whose tag is clear leaves its word and flag unchanged.
- R8: A host pop of a receive slot clears its valid flag and sets its word to zero in the next cycle. The other slot is unaffected.
- R9: Read-done is 1 exactly when both receive slots are valid. The returned index output shows bits 18:12 of the slot 1 receive word, and the returned data output shows bits 19:4 of the slot 2 receive word.
- R10: The transmitted slot words and tags change only on the cycle after a frame strobe. A frame strobe with nothing sendable yields zero words with both tags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_tx1_we | input | 1 | Load slot 1 holding register (arms the transfer) |
| host_tx1_wdata | input | 20 | Slot 1 command word |
| host_tx2_we | input | 1 | Load slot 2 holding register |
| host_tx2_wdata | input | 20 | Slot 2 data word |
| host_rx1_pop | input | 1 | Read out and empty slot 1 receive word |
| host_rx2_pop | input | 1 | Read out and empty slot 2 receive word |
| host_rx1_word | output | 20 | Slot 1 receive word |
| host_rx2_word | output | 20 | Slot 2 receive word |
| host_rx_index | output | 7 | Echoed register index, bits 18:12 of slot 1 receive |
| host_rx_data | output | 16 | Returned data, bits 19:4 of slot 2 receive |
| stat_tx1_busy | output | 1 | Slot 1 word waiting to be sent |
| stat_tx2_busy | output | 1 | Slot 2 word waiting to be sent |
| stat_rx1_valid | output | 1 | Slot 1 receive word holds a fresh value |
| stat_rx2_valid | output | 1 | Slot 2 receive word holds a fresh value |
| stat_read_done | output | 1 | Both receive slots valid |
| link_tx1_en | input | 1 | Slot 1 transmit enable |
| link_tx2_en | input | 1 | Slot 2 transmit enable |
| link_frame_strobe | input | 1 | One-cycle pulse: latch slot words for the next frame |
| link_tx_slot1 | output | 20 | Slot 1 word for the current frame |
| link_tx_slot2 | output | 20 | Slot 2 word for the current frame |
| link_tx_tag1 | output | 1 | Slot 1 tag valid for the current frame |
| link_tx_tag2 | output | 1 | Slot 2 tag valid for the current frame |
| link_rx_strobe | input | 1 | One-cycle pulse: receive slot words are present |
| link_rx_tag1 | input | 1 | Received slot 1 tag valid |
| link_rx_tag2 | input | 1 | Received slot 2 tag valid |
| link_rx_slot1 | input | 20 | Received slot 1 word |
| link_rx_slot2 | input | 20 | Received slot 2 word |

## Verification
A wrong busy flag shows up at the next frame strobe. One fault is a write that leaves without its data word, seen as tag1 without tag2. Another is a request that is never sent, seen as a busy flag that stays set through an enabled frame. Either shows on the slot outputs one cycle after the strobe. A wrong receive valid flag or word shows one cycle after the receive strobe or the pop, on the valid flags, the read-done flag and the decoded index and data outputs.

// File: rtl/codec_reg_pkg.sv
// Shared slot geometry for the codec register access engine.
// Assumes 20-bit slot words with fixed field positions.
package codec_reg_pkg;
    localparam int SLOT_W   = 20;
    localparam int IDX_W    = 7;
    localparam int IDX_LSB  = 12;
    localparam int DATA_W   = 16;
    localparam int DATA_LSB = 4;
    localparam int REQ_BIT  = 19;
    localparam int NUM_RX   = 2;
    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/codec_tx_sched.sv
// Transmit holding registers and frame scheduler.
// It holds the command and data words and decides at each frame strobe
// what leaves. A write needs both words present; a read goes out alone.
// Assumes frame_strobe is a single-cycle pulse per frame.
module codec_tx_sched
    import codec_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx1_we,
    input  slot_t tx1_wdata,
    input  logic  tx2_we,
    input  slot_t tx2_wdata,
    input  logic  tx1_en,
    input  logic  tx2_en,
    input  logic  frame_strobe,
    output logic  busy1,
    output logic  busy2,
    output slot_t frm_slot1,
    output slot_t frm_slot2,
    output logic  frm_tag1,
    output logic  frm_tag2
);
    slot_t hold1, hold2;
    logic  is_read, send_rd, send_wr, send_any;

    // Classify the pending request and check that its slots are enabled.
    always_comb begin
        is_read  = hold1[REQ_BIT];
        send_rd  = busy1 && is_read && tx1_en;
        send_wr  = busy1 && !is_read && busy2 && tx1_en && tx2_en;
        send_any = send_rd || send_wr;
    end

    // Capture host words into the holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold1 <= '0;
            hold2 <= '0;
        end else begin
            if (tx1_we) hold1 <= tx1_wdata;
            if (tx2_we) hold2 <= tx2_wdata;
        end
    end

    // Busy flags: set on load, cleared when the slot is sent. A new load wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy1 <= 1'b0;
            busy2 <= 1'b0;
        end else begin
            if (tx1_we)                   busy1 <= 1'b1;
            else if (frame_strobe && send_any) busy1 <= 1'b0;
            if (tx2_we)                   busy2 <= 1'b1;
            else if (frame_strobe && send_wr)  busy2 <= 1'b0;
        end
    end

    // Latch the outgoing frame words and tags at each frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm_slot1 <= '0;
            frm_slot2 <= '0;
            frm_tag1  <= 1'b0;
            frm_tag2  <= 1'b0;
        end else if (frame_strobe) begin
            frm_slot1 <= send_any ? hold1 : '0;
            frm_slot2 <= send_wr  ? hold2 : '0;
            frm_tag1  <= send_any;
            frm_tag2  <= send_wr;
        end
    end

    // A data slot never leaves without its address slot.
    assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frm_tag2 |-> frm_tag1);

    // An enabled read is sent and its busy flag drops.
    assert_read_sent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && busy1 && hold1[REQ_BIT] && tx1_en && !tx1_we)
        |=> (!busy1 && frm_tag1 && !frm_tag2));

    // A write without its data word is held.
    assert_write_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_strobe && busy1 && !hold1[REQ_BIT] && !busy2)
        |=> (busy1 && !frm_tag1));

    // Frame outputs move only after a strobe.
    assert_frame_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |=> ($stable(frm_slot1) && $stable(frm_slot2)
                           && $stable(frm_tag1) && $stable(frm_tag2)));
endmodule

// File: rtl/codec_rx_slot.sv
// One receive holding register with its valid flag.
// It captures a tagged slot at the receive strobe and empties it on a host pop.
// Assumes a capture in the same cycle as a pop takes precedence.
module codec_rx_slot
    import codec_reg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  strobe,
    input  logic  tag,
    input  slot_t slot_in,
    input  logic  pop,
    output slot_t word,
    output logic  valid
);
    logic capture;

    // A slot is taken only when the frame tags it valid.
    always_comb capture = strobe && tag;

    // Hold the received word; a pop empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else if (capture) begin
            word  <= slot_in;
            valid <= 1'b1;
        end else if (pop) begin
            word  <= '0;
            valid <= 1'b0;
        end
    end

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && tag) |=> (valid && word == $past(slot_in)));

    assert_untagged_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!(strobe && tag) && !pop) |=> ($stable(word) && $stable(valid)));

    assert_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !(strobe && tag)) |=> (!valid && word == '0));
endmodule

// File: rtl/codec_reg_engine.sv
// Codec register access engine top level.
// It joins the transmit scheduler with two receive slot holders and
// decodes the returned index and data fields for the host.
// Assumes every strobe and host load or pop is a single-cycle pulse.
module codec_reg_engine
    import codec_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_tx1_we,
    input  logic [SLOT_W-1:0] host_tx1_wdata,
    input  logic              host_tx2_we,
    input  logic [SLOT_W-1:0] host_tx2_wdata,
    input  logic              host_rx1_pop,
    input  logic              host_rx2_pop,
    output logic [SLOT_W-1:0] host_rx1_word,
    output logic [SLOT_W-1:0] host_rx2_word,
    output logic [IDX_W-1:0]  host_rx_index,
    output logic [DATA_W-1:0] host_rx_data,
    output logic              stat_tx1_busy,
    output logic              stat_tx2_busy,
    output logic              stat_rx1_valid,
    output logic              stat_rx2_valid,
    output logic              stat_read_done,
    input  logic              link_tx1_en,
    input  logic              link_tx2_en,
    input  logic              link_frame_strobe,
    output logic [SLOT_W-1:0] link_tx_slot1,
    output logic [SLOT_W-1:0] link_tx_slot2,
    output logic              link_tx_tag1,
    output logic              link_tx_tag2,
    input  logic              link_rx_strobe,
    input  logic              link_rx_tag1,
    input  logic              link_rx_tag2,
    input  logic [SLOT_W-1:0] link_rx_slot1,
    input  logic [SLOT_W-1:0] link_rx_slot2
);
    slot_t              rx_in   [NUM_RX];
    slot_t              rx_word [NUM_RX];
    logic  [NUM_RX-1:0] rx_tag, rx_pop, rx_valid;

    codec_tx_sched u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx1_we       (host_tx1_we),
        .tx1_wdata    (host_tx1_wdata),
        .tx2_we       (host_tx2_we),
        .tx2_wdata    (host_tx2_wdata),
        .tx1_en       (link_tx1_en),
        .tx2_en       (link_tx2_en),
        .frame_strobe (link_frame_strobe),
        .busy1        (stat_tx1_busy),
        .busy2        (stat_tx2_busy),
        .frm_slot1    (link_tx_slot1),
        .frm_slot2    (link_tx_slot2),
        .frm_tag1     (link_tx_tag1),
        .frm_tag2     (link_tx_tag2)
    );

    // Gather per-slot receive inputs into arrays.
    always_comb begin
        rx_in[0] = link_rx_slot1;
        rx_in[1] = link_rx_slot2;
        rx_tag   = {link_rx_tag2, link_rx_tag1};
        rx_pop   = {host_rx2_pop, host_rx1_pop};
    end

    for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
        codec_rx_slot u_rx (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (link_rx_strobe),
            .tag     (rx_tag[g]),
            .slot_in (rx_in[g]),
            .pop     (rx_pop[g]),
            .word    (rx_word[g]),
            .valid   (rx_valid[g])
        );
    end

    // Present receive status and decoded fields to the host.
    always_comb begin
        host_rx1_word  = rx_word[0];
        host_rx2_word  = rx_word[1];
        stat_rx1_valid = rx_valid[0];
        stat_rx2_valid = rx_valid[1];
        stat_read_done = &rx_valid;
        host_rx_index  = rx_word[0][IDX_LSB +: IDX_W];
        host_rx_data   = rx_word[1][DATA_LSB +: DATA_W];
    end

    assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_read_done |-> (stat_rx1_valid && stat_rx2_valid));
endmodule

// File: tb/codec_reg_engine_tb.sv
module codec_reg_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx1_we = 0, tx2_we = 0, pop1 = 0, pop2 = 0;
    logic [19:0] tx1_d = 0, tx2_d = 0;
    logic [19:0] rxw1, rxw2, ts1, ts2;
    logic [6:0]  ridx;
    logic [15:0] rdat;
    logic        b1, b2, v1, v2, done, tg1, tg2;
    logic        en1 = 1, en2 = 1, fstb = 0, rstb = 0, rt1 = 0, rt2 = 0;
    logic [19:0] rs1 = 0, rs2 = 0;
    int          nchk = 0, nerr = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    codec_reg_engine u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_tx1_we(tx1_we), .host_tx1_wdata(tx1_d),
        .host_tx2_we(tx2_we), .host_tx2_wdata(tx2_d),
        .host_rx1_pop(pop1), .host_rx2_pop(pop2),
        .host_rx1_word(rxw1), .host_rx2_word(rxw2),
        .host_rx_index(ridx), .host_rx_data(rdat),
        .stat_tx1_busy(b1), .stat_tx2_busy(b2),
        .stat_rx1_valid(v1), .stat_rx2_valid(v2), .stat_read_done(done),
        .link_tx1_en(en1), .link_tx2_en(en2), .link_frame_strobe(fstb),
        .link_tx_slot1(ts1), .link_tx_slot2(ts2),
        .link_tx_tag1(tg1), .link_tx_tag2(tg2),
        .link_rx_strobe(rstb), .link_rx_tag1(rt1), .link_rx_tag2(rt2),
        .link_rx_slot1(rs1), .link_rx_slot2(rs2)
    );

    function automatic logic [19:0] cmd_word(logic rd, logic [6:0] idx);
        return {rd, idx, 12'h000};
    endfunction

    function automatic logic [19:0] data_word(logic [15:0] d);
        return {d, 4'h0};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: inputs set before are captured; outputs sampled 1 ns later.
    task automatic step();
        @(posedge clk); #1;
        tx1_we = 0; tx2_we = 0; pop1 = 0; pop2 = 0; fstb = 0; rstb = 0;
    endtask

    task automatic frame_chk(string req, logic et1, logic et2, logic [19:0] e1,
                             logic [19:0] e2, logic eb1, logic eb2);
        chk(req, "tag1", tg1, et1);
        chk(req, "tag2", tg2, et2);
        chk(req, "slot1", ts1, e1);
        chk(req, "slot2", ts2, e2);
        chk(req, "busy1", b1, eb1);
        chk(req, "busy2", b2, eb2);
    endtask

    // Transmit and receive reference model state.
    logic        m_b1 = 0, m_b2 = 0, m_v1 = 0, m_v2 = 0;
    logic [19:0] m_h1 = 0, m_h2 = 0, m_w1 = 0, m_w2 = 0;

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        frame_chk("R1", 0, 0, 0, 0, 0, 0);
        chk("R1", "rx valid", {v1, v2, done}, 3'b000);
        chk("R1", "rx words", {rxw1, rxw2}, 40'h0);

        // R5: write address without data is held
        tx1_we = 1; tx1_d = cmd_word(0, 7'h02); step();
        chk("R2", "busy1 after load", b1, 1);
        fstb = 1; step();
        frame_chk("R5", 0, 0, 0, 0, 1, 0);
        // R2: load data word
        tx2_we = 1; tx2_d = data_word(16'hBEEF); step();
        chk("R2", "busy2 after load", b2, 1);
        // R6: write needs both enables
        en2 = 0; fstb = 1; step();
        frame_chk("R6", 0, 0, 0, 0, 1, 1);
        en2 = 1; fstb = 1; step();
        frame_chk("R4", 1, 1, 20'h02000, 20'hBEEF0, 0, 0);
        // R10: outputs hold without strobe, then an idle strobe clears them
        step();
        frame_chk("R10", 1, 1, 20'h02000, 20'hBEEF0, 0, 0);
        fstb = 1; step();
        frame_chk("R10", 0, 0, 0, 0, 0, 0);

        // R6 / R3: read request held while slot 1 disabled, then sent
        tx2_we = 1; tx2_d = data_word(16'h1234); step();
        tx1_we = 1; tx1_d = cmd_word(1, 7'h7C); step();
        en1 = 0; fstb = 1; step();
        frame_chk("R6", 0, 0, 0, 0, 1, 1);
        en1 = 1; fstb = 1; step();
        frame_chk("R3", 1, 0, 20'hFC000, 0, 0, 1);
        // leftover data word now pairs with a new write
        tx1_we = 1; tx1_d = cmd_word(0, 7'h11); step();
        fstb = 1; step();
        frame_chk("R4", 1, 1, 20'h11000, 20'h12340, 0, 0);

        // R7: only tagged slots captured
        rstb = 1; rt1 = 1; rt2 = 0; rs1 = 20'hFC000; rs2 = 20'hAAAAA; step();
        chk("R7", "v1", v1, 1); chk("R7", "v2", v2, 0);
        chk("R7", "word2 untouched", rxw2, 0);
        chk("R9", "done one slot", done, 0);
        rstb = 1; rt1 = 0; rt2 = 1; rs1 = 20'h55555; rs2 = 20'h9ABC0; step();
        chk("R7", "word1 kept", rxw1, 20'hFC000);
        chk("R9", "done", done, 1);
        chk("R9", "index", ridx, 7'h7C);
        chk("R9", "data", rdat, 16'h9ABC);
        rstb = 1; rt1 = 1; rt2 = 0; rs1 = 20'h3A000; step();
        chk("R7", "overwrite", rxw1, 20'h3A000);
        chk("R9", "index after overwrite", ridx, 7'h3A);
        // R8: pop slot 1 only
        pop1 = 1; step();
        chk("R8", "v1 cleared", v1, 0);
        chk("R8", "word1 zero", rxw1, 0);
        chk("R8", "v2 kept", v2, 1);
        chk("R9", "done after pop", done, 0);
        pop2 = 1; step();
        chk("R8", "v2 cleared", v2, 0);
        chk("R8", "word2 zero", rxw2, 0);
        rt1 = 0; rt2 = 0;

        // Constrained random: transmit and receive against the model
        for (int it = 0; it < 300; it++) begin
            logic srd, swr;
            if ($urandom % 2) begin
                tx2_we = 1; tx2_d = 20'($urandom); step();
                m_b2 = 1; m_h2 = tx2_d;
                chk("R2", "rand busy2", b2, 1);
            end
            if ($urandom % 4 != 0) begin
                tx1_we = 1; tx1_d = cmd_word(1'($urandom), 7'($urandom)); step();
                m_b1 = 1; m_h1 = tx1_d;
                chk("R2", "rand busy1", b1, 1);
            end
            en1 = ($urandom % 4 != 0); en2 = ($urandom % 4 != 0);
            fstb = 1; step();
            srd = m_b1 && m_h1[19] && en1;
            swr = m_b1 && !m_h1[19] && m_b2 && en1 && en2;
            if (srd || swr) m_b1 = 0;
            if (swr) m_b2 = 0;
            frame_chk(swr ? "R4" : (srd ? "R3" : "R6"), srd | swr, swr,
                      (srd | swr) ? m_h1 : 20'h0, swr ? m_h2 : 20'h0, m_b1, m_b2);

            rt1 = 1'($urandom); rt2 = 1'($urandom);
            rs1 = 20'($urandom); rs2 = 20'($urandom);
            rstb = 1; step();
            if (rt1) begin m_v1 = 1; m_w1 = rs1; end
            if (rt2) begin m_v2 = 1; m_w2 = rs2; end
            chk("R7", "rand word1", rxw1, m_w1);
            chk("R7", "rand word2", rxw2, m_w2);
            chk("R9", "rand done", done, m_v1 & m_v2);
            chk("R9", "rand fields", {ridx, rdat}, {m_w1[18:12], m_w2[19:4]});
            pop1 = 1'($urandom); pop2 = 1'($urandom);
            begin
                logic p1, p2;
                p1 = pop1; p2 = pop2;
                step();
                if (p1) begin m_v1 = 0; m_w1 = 0; end
                if (p2) begin m_v2 = 0; m_w2 = 0; end
            end
            chk("R8", "rand valid", {v1, v2}, {m_v1, m_v2});
            chk("R8", "rand words", {rxw1, rxw2}, {m_w1, m_w2});
        end

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end
endmodule